// File: doc/BRIEF.md
# Holdover Frequency History Accumulator

This block keeps three averaged copies of a DPLL's frequency control word so that holdover logic has something to fall back on when every reference is lost. A short-term average follows the frequency word at all times through a single-pole low-pass filter with a selectable bandwidth. A long-term average uses a much narrower single-pole filter. It builds up only while the loop is synchronized to a reference, and it is discarded whenever that reference relationship is broken. A device holdover value is a copy of the long-term average. It is refreshed only once the long-term average has gone through its initial fast-settling phase.

The long-term filter starts each accumulation with an express phase. For a programmable number of one-second ticks (900 by default, i.e. 15 minutes), it runs with a time constant sixteen times shorter than the one selected, so that it settles quickly. After that it switches to the selected time constant, and the device holdover value starts following it. A reference switch, a loss of lock, a drop of the sync indication or a flush write each throw the long-term average away and freeze the device value at its last copy. A flush write with its data bit set also clears the device value.

Top module: `holdover_hist`

## Requirements
- R1: After reset all three histories are 0, and both `dev_valid` and `dev_updating` are 0.
- R2: On each cycle with `freq_vld` high, the short-term history y becomes y + ((x − y) >>> (ST_BASE + `st_bw_sel`)) in signed two's-complement arithmetic, with the shift flooring. x is `freq_in`. Selection 0 is the widest bandwidth, and each step up halves it. Without `freq_vld` the history holds.
- R3: The short-term history is unaffected by `synced`, `ref_switch`, `lock_lost` and flush writes; only `rst_n` clears it.
- R4: Outside the express phase, a long-term sample uses shift LT_BASE + min(`lt_bw_sel`, 5), which gives six settings; codes 6 and 7 act as 5.
- R5: Long-term accumulation is armed by a rising edge of `synced`. Sample updates begin in the cycle after that edge and happen only on `freq_vld` cycles while armed. In every other cycle without a restart, the long-term history holds.
- R6: For the first EXPRESS_TICKS `sec_tick` pulses after arming, long-term samples use shift max(s − 4, 1), where s is the R4 shift. The tick that completes the count ends the express phase, and ticks are ignored while the block is not armed.
- R7: A restart happens on a `ref_switch` pulse, on a `lock_lost` pulse, on a falling edge of `synced`, or on a flush write (`flush_wr`) with either data value. A restart zeroes the long-term history, disarms it and restarts the express count. A restart takes priority over a rising edge of `synced` in the same cycle, and the block then stays disarmed until the next rising edge.
- R8: While armed, past the express phase and with no restart in the cycle, `dev_updating` is 1 and the device history takes the current long-term history at the next edge. Otherwise `dev_updating` is 0.
- R9: Once copying stops, the device history keeps its last copied value through restarts and re-accumulation until copying resumes.
- R10: A flush write with `flush_data` = 1 clears the device history and `dev_valid`. With `flush_data` = 0 both are left unchanged.
- R11: `dev_valid` rises with the first copy into the device history and stays high until a flush write with data 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freq_in | input | W | Signed frequency word from the DPLL |
| freq_vld | input | 1 | Sample strobe for `freq_in` |
| st_bw_sel | input | 2 | Short-term bandwidth select (0 widest) |
| lt_bw_sel | input | 3 | Long-term bandwidth select (0 widest, 6 and 7 act as 5) |
| synced | input | 1 | Loop synchronized to the selected reference (level) |
| ref_switch | input | 1 | Pulse: active reference changed |
| lock_lost | input | 1 | Pulse: loss of lock |
| flush_wr | input | 1 | Flush write strobe |
| flush_data | input | 1 | Flush write data bit |
| sec_tick | input | 1 | One-second timing pulse |
| st_hist | output | W | Short-term history |
| lt_hist | output | W | Long-term history |
| dev_hist | output | W | Device holdover history |
| dev_valid | output | 1 | Device history holds a copy |
| dev_updating | output | 1 | Device history is being refreshed this cycle |

## Verification
The short-term filter is driven at every bandwidth code with full-scale steps of both signs, with alternating extremes and with random words. Sample gaps are inserted to separate the flooring shift and the hold behaviour from errors in the shift amount. The long-term path is swept over all eight bandwidth codes, once in the express phase and once after it, which separates the clamp at shift 1 and the code-5 saturation from the normal shift. Each restart cause is exercised on its own and also together with a rising edge of sync. The bench then checks where copying stops, that the device value persists, and the difference between the two flush data values.

// File: rtl/hh_pkg.sv
package hh_pkg;

    localparam int ST_SETTINGS = 4;
    localparam int LT_SETTINGS = 6;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_EXPRESS = 2'd1,
        PH_STEADY  = 2'd2
    } lt_phase_e;

    function automatic int unsigned express_shift(int unsigned s, int unsigned delta);
        if (s > delta + 1) return s - delta;
        return 1;
    endfunction

    function automatic int unsigned lt_code_clamp(logic [2:0] code);
        if (int'(code) > LT_SETTINGS - 1) return LT_SETTINGS - 1;
        return int'(code);
    endfunction

endpackage

// File: rtl/hh_lpf.sv
module hh_lpf #(
    parameter int W   = 32,
    parameter int SHW = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                upd,
    input  logic signed [W-1:0] x,
    input  logic [SHW-1:0]      shift,
    output logic signed [W-1:0] y
);

    logic signed [W-1:0] y_d, y_q;
    logic signed [W:0]   diff_w;
    logic signed [W:0]   step_w;

    always_comb begin
        diff_w = {x[W-1], x} - {y_q[W-1], y_q};
        step_w = diff_w >>> shift;
        y_d    = y_q;
        if (clr) begin
            y_d = '0;
        end else if (upd) begin
            y_d = y_q + step_w[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) y_q <= '0;
        else        y_q <= y_d;
    end

    assign y = y_q;

    // R2: no sample and no clear leaves the average untouched
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !upd) |=> $stable(y_q));

    // R2: an update lands between the old average and the sample
    a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clr && (x >= y_q)) |=> ((y_q >= $past(y_q)) && (y_q <= $past(x))));

    a_r2_bounded_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clr && (x < y_q)) |=> ((y_q <= $past(y_q)) && (y_q >= $past(x))));

endmodule

// File: rtl/hh_ctrl.sv
module hh_ctrl #(
    parameter int EXPRESS_TICKS = 900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic synced,
    input  logic ref_switch,
    input  logic lock_lost,
    input  logic flush_wr,
    input  logic flush_data,
    input  logic sec_tick,
    output logic restart,
    output logic armed,
    output logic express,
    output logic copy_en,
    output logic dev_clr
);
    import hh_pkg::*;

    localparam int CW = (EXPRESS_TICKS < 2) ? 1 : $clog2(EXPRESS_TICKS);

    typedef struct packed {
        lt_phase_e     phase;
        logic [CW-1:0] cnt;
        logic          sync_q;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  sync_rise;
    logic  sync_fall;

    always_comb begin
        sync_rise = synced && !s_q.sync_q;
        sync_fall = !synced && s_q.sync_q;
        restart   = ref_switch || lock_lost || flush_wr || sync_fall;

        s_d        = s_q;
        s_d.sync_q = synced;
        if (restart) begin
            s_d.phase = PH_IDLE;
            s_d.cnt   = '0;
        end else begin
            unique case (s_q.phase)
                PH_IDLE: begin
                    if (sync_rise) begin
                        s_d.phase = PH_EXPRESS;
                        s_d.cnt   = '0;
                    end
                end
                PH_EXPRESS: begin
                    if (sec_tick) begin
                        if (s_q.cnt == CW'(EXPRESS_TICKS - 1)) s_d.phase = PH_STEADY;
                        else                                   s_d.cnt   = s_q.cnt + 1'b1;
                    end
                end
                PH_STEADY: ;
                default: s_d.phase = PH_IDLE;
            endcase
        end

        armed   = (s_q.phase != PH_IDLE);
        express = (s_q.phase == PH_EXPRESS);
        copy_en = (s_q.phase == PH_STEADY) && !restart;
        dev_clr = flush_wr && flush_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase  <= PH_IDLE;
            s_q.cnt    <= '0;
            s_q.sync_q <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // R6: express count never reaches the limit
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_EXPRESS) |-> (int'(s_q.cnt) < EXPRESS_TICKS));

    // R7: restart always leaves the block disarmed
    a_r7_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (s_q.phase == PH_IDLE));

    // R5: arming only follows a rising sync edge
    a_r5_arm_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.phase == PH_IDLE) && !(synced && !s_q.sync_q)) |=> (s_q.phase == PH_IDLE));

endmodule

// File: rtl/hh_devhold.sv
module hh_devhold #(
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                copy_en,
    input  logic                clr,
    input  logic signed [W-1:0] src,
    output logic signed [W-1:0] dev,
    output logic                valid
);

    typedef struct packed {
        logic [W-1:0] val;
        logic         ok;
    } dh_t;

    dh_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (clr) begin
            h_d.val = '0;
            h_d.ok  = 1'b0;
        end else if (copy_en) begin
            h_d.val = src;
            h_d.ok  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q.val <= '0;
            h_q.ok  <= 1'b0;
        end else begin
            h_q <= h_d;
        end
    end

    assign dev   = h_q.val;
    assign valid = h_q.ok;

    // R9: without a copy or clear the holdover value persists
    a_r9_persist: assert property (@(posedge clk) disable iff (!rst_n)
        (!copy_en && !clr) |=> ($stable(h_q.val) && $stable(h_q.ok)));

    // R11: a copy always leaves the value valid
    a_r11_valid_after_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_en && !clr) |=> h_q.ok);

endmodule

// File: rtl/holdover_hist.sv
module holdover_hist #(
    parameter int W             = 32,
    parameter int ST_BASE       = 6,
    parameter int LT_BASE       = 14,
    parameter int EXPRESS_TICKS = 900,
    parameter int EXPRESS_DELTA = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] freq_in,
    input  logic         freq_vld,
    input  logic [1:0]   st_bw_sel,
    input  logic [2:0]   lt_bw_sel,
    input  logic         synced,
    input  logic         ref_switch,
    input  logic         lock_lost,
    input  logic         flush_wr,
    input  logic         flush_data,
    input  logic         sec_tick,
    output logic [W-1:0] st_hist,
    output logic [W-1:0] lt_hist,
    output logic [W-1:0] dev_hist,
    output logic         dev_valid,
    output logic         dev_updating
);
    import hh_pkg::*;

    localparam int ST_MAX = ST_BASE + ST_SETTINGS;
    localparam int LT_MAX = LT_BASE + LT_SETTINGS;
    localparam int SHW    = $clog2((ST_MAX > LT_MAX) ? ST_MAX : LT_MAX);

    logic               lt_restart;
    logic               lt_armed;
    logic               lt_express;
    logic               lt_copy;
    logic               dh_clr;
    logic [SHW-1:0]     st_shift;
    logic [SHW-1:0]     lt_shift;
    logic signed [W-1:0] x_s;
    logic signed [W-1:0] st_y, lt_y, dev_y;
    int unsigned        lt_norm;

    assign x_s = $signed(freq_in);

    always_comb begin
        st_shift = SHW'(ST_BASE + int'(st_bw_sel));
        lt_norm  = LT_BASE + lt_code_clamp(lt_bw_sel);
        if (lt_express) lt_shift = SHW'(express_shift(lt_norm, EXPRESS_DELTA));
        else            lt_shift = SHW'(lt_norm);
    end

    hh_ctrl #(
        .EXPRESS_TICKS(EXPRESS_TICKS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .synced    (synced),
        .ref_switch(ref_switch),
        .lock_lost (lock_lost),
        .flush_wr  (flush_wr),
        .flush_data(flush_data),
        .sec_tick  (sec_tick),
        .restart   (lt_restart),
        .armed     (lt_armed),
        .express   (lt_express),
        .copy_en   (lt_copy),
        .dev_clr   (dh_clr)
    );

    hh_lpf #(.W(W), .SHW(SHW)) u_st (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (1'b0),
        .upd  (freq_vld),
        .x    (x_s),
        .shift(st_shift),
        .y    (st_y)
    );

    hh_lpf #(.W(W), .SHW(SHW)) u_lt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (lt_restart),
        .upd  (freq_vld && lt_armed),
        .x    (x_s),
        .shift(lt_shift),
        .y    (lt_y)
    );

    hh_devhold #(.W(W)) u_dev (
        .clk    (clk),
        .rst_n  (rst_n),
        .copy_en(lt_copy),
        .clr    (dh_clr),
        .src    (lt_y),
        .dev    (dev_y),
        .valid  (dev_valid)
    );

    assign st_hist      = st_y;
    assign lt_hist      = lt_y;
    assign dev_hist     = dev_y;
    assign dev_updating = lt_copy;

    // R7: any restart cause empties the long-term average
    a_r7_lt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        lt_restart |=> (lt_hist == '0));

    // R5: long-term average moves only on a sample or a restart
    a_r5_lt_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!freq_vld && !lt_restart) |=> $stable(lt_hist));

    // R10: a flush with data 1 empties the holdover value
    a_r10_flush_one: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_wr && flush_data) |=> (!dev_valid && dev_hist == '0));

    // R8: a restart stops the refresh of the holdover value
    a_r8_stop_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
        lt_restart |=> !dev_updating);

    // R4: shift always lies inside the long-term range
    a_r4_shift_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lt_shift) >= 1) && (int'(lt_shift) <= LT_BASE + LT_SETTINGS - 1));

endmodule

// File: tb/sim_holdover_hist.sv
`timescale 1ns/1ps
module sim_holdover_hist;

    localparam int W  = 16;
    localparam int SB = 1;
    localparam int LB = 2;
    localparam int ET = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] freq_in = '0;
    logic         freq_vld = 1'b0;
    logic [1:0]   st_bw_sel = '0;
    logic [2:0]   lt_bw_sel = '0;
    logic         synced = 1'b0;
    logic         ref_switch = 1'b0;
    logic         lock_lost = 1'b0;
    logic         flush_wr = 1'b0;
    logic         flush_data = 1'b0;
    logic         sec_tick = 1'b0;
    logic [W-1:0] st_hist, lt_hist, dev_hist;
    logic         dev_valid, dev_updating;

    always #2 clk = ~clk;

    holdover_hist #(
        .W(W), .ST_BASE(SB), .LT_BASE(LB), .EXPRESS_TICKS(ET), .EXPRESS_DELTA(4)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .freq_in(freq_in), .freq_vld(freq_vld),
        .st_bw_sel(st_bw_sel), .lt_bw_sel(lt_bw_sel), .synced(synced),
        .ref_switch(ref_switch), .lock_lost(lock_lost), .flush_wr(flush_wr),
        .flush_data(flush_data), .sec_tick(sec_tick), .st_hist(st_hist),
        .lt_hist(lt_hist), .dev_hist(dev_hist), .dev_valid(dev_valid),
        .dev_updating(dev_updating)
    );

    int  vectors = 0;
    int  errors = 0;
    bit  done = 0;
    int  m_st = 0, m_lt = 0, m_dev = 0;
    bit  m_valid = 0;
    int  m_phase = 0, m_cnt = 0;
    bit  m_syncq = 0;

    function automatic int filt(int y, int x, int k);
        return y + ((x - y) >>> k);
    endfunction

    function automatic bit restart_now();
        return ref_switch || lock_lost || flush_wr || (m_syncq && !synced);
    endfunction

    task automatic cmp(string tag, int got, int exp);
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic check();
        bit exp_upd;
        vectors++;
        exp_upd = (m_phase == 2) && !restart_now();
        cmp("R2/R3 st_hist", int'($signed(st_hist)), m_st);
        cmp("R4-R7 lt_hist", int'($signed(lt_hist)), m_lt);
        cmp("R9 dev_hist", int'($signed(dev_hist)), m_dev);
        cmp("R11 dev_valid", int'(dev_valid), int'(m_valid));
        cmp("R8 dev_updating", int'(dev_updating), int'(exp_upd));
    endtask

    // one clock: advance the model from the present inputs, then compare
    task automatic step();
        bit rs;
        int k, x;
        int n_st, n_lt, n_dev, n_phase, n_cnt;
        bit n_valid;
        rs = restart_now();
        x = int'($signed(freq_in));
        n_st = m_st; n_lt = m_lt; n_dev = m_dev; n_valid = m_valid;
        n_phase = m_phase; n_cnt = m_cnt;
        if (freq_vld) n_st = filt(m_st, x, SB + int'(st_bw_sel));
        if (rs) n_lt = 0;
        else if (freq_vld && m_phase != 0) begin
            k = LB + ((int'(lt_bw_sel) > 5) ? 5 : int'(lt_bw_sel));
            if (m_phase == 1) k = (k > 5) ? k - 4 : 1;
            n_lt = filt(m_lt, x, k);
        end
        if (flush_wr && flush_data) begin
            n_dev = 0; n_valid = 0;
        end else if (m_phase == 2 && !rs) begin
            n_dev = m_lt; n_valid = 1;
        end
        if (rs) begin
            n_phase = 0; n_cnt = 0;
        end else if (m_phase == 0) begin
            if (synced && !m_syncq) begin n_phase = 1; n_cnt = 0; end
        end else if (m_phase == 1 && sec_tick) begin
            if (m_cnt == ET - 1) n_phase = 2;
            else n_cnt = m_cnt + 1;
        end
        @(posedge clk);
        m_st = n_st; m_lt = n_lt; m_dev = n_dev; m_valid = n_valid;
        m_phase = n_phase; m_cnt = n_cnt; m_syncq = synced;
        @(negedge clk);
        check();
        ref_switch = 0; lock_lost = 0; flush_wr = 0; flush_data = 0; sec_tick = 0;
    endtask

    task automatic sample(int v);
        freq_in = W'(v); freq_vld = 1; step(); freq_vld = 0;
    endtask

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        seed = 7;
        repeat (3) @(negedge clk);
        // R1: reset state
        check();
        rst_n = 1;
        @(negedge clk);
        check();

        // R2: every short-term code with steps, extremes and gaps
        for (int s = 0; s < 4; s++) begin
            st_bw_sel = 2'(s);
            for (int i = 0; i < 12; i++) sample(32767);
            step();
            for (int i = 0; i < 12; i++) sample(-32768);
            for (int i = 0; i < 10; i++) sample((i % 2) ? 32767 : -32768);
            for (int i = 0; i < 6; i++) sample(-1);
            step(); step();
        end

        // R3: events around the short-term path leave it alone
        st_bw_sel = 2'd2;
        sample(1000);
        ref_switch = 1; step();
        lock_lost = 1; step();
        flush_wr = 1; flush_data = 1; step();
        synced = 1; step(); synced = 0; step();

        // R5, R6, R4: arm, then sweep lt codes in express and steady
        synced = 1; step();
        for (int c = 0; c < 8; c++) begin
            lt_bw_sel = 3'(c);
            sample(20000); sample(-20000); sample(5);
        end
        for (int t = 0; t < ET; t++) begin sec_tick = 1; sample(3000 + t); end
        // R8 and R11: copying now active
        for (int c = 0; c < 8; c++) begin
            lt_bw_sel = 3'(c);
            sample(-12000); sample(12000); step();
        end
        // R9: switch freezes the device value through rebuild
        ref_switch = 1; sample(777);
        for (int i = 0; i < 4; i++) sample(-500);
        synced = 0; step(); synced = 1; step();
        for (int t = 0; t < ET - 1; t++) begin sec_tick = 1; sample(400); end
        step();
        // R7: restart together with sync rise stays disarmed
        synced = 0; step();
        synced = 1; lock_lost = 1; step();
        for (int t = 0; t < ET + 2; t++) begin sec_tick = 1; sample(900); end
        synced = 0; step(); synced = 1; step();
        for (int t = 0; t < ET; t++) begin sec_tick = 1; sample(1500); end
        sample(1600);
        // R10: flush with data 0 keeps, data 1 clears
        flush_wr = 1; flush_data = 0; step();
        step();
        synced = 0; step(); synced = 1; step();
        for (int t = 0; t < ET; t++) begin sec_tick = 1; sample(-800); end
        sample(-900);
        flush_wr = 1; flush_data = 1; step();
        step();

        // near-exhaustive sweep of both selects with random traffic
        for (int combo = 0; combo < 32; combo++) begin
            st_bw_sel = 2'(combo % 4);
            lt_bw_sel = 3'(combo / 4);
            for (int i = 0; i < 100; i++) begin
                int r;
                r = $urandom(seed); seed = seed + 1;
                freq_in  = W'(r);
                freq_vld = (r[20:18] != 3'd0);
                sec_tick = (r[23:22] == 2'd0);
                if (r[31:25] == 7'd1) ref_switch = 1;
                if (r[31:25] == 7'd2) lock_lost = 1;
                if (r[31:25] == 7'd3) begin flush_wr = 1; flush_data = r[24]; end
                if (synced && r[31:24] == 8'd9) synced = 0;
                else if (!synced && r[17:15] == 3'd0) synced = 1;
                step();
                freq_vld = 0;
            end
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule